// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block behaves like a small serial EEPROM attached to a three-wire bus: a chip-select, a serial clock and a data input, plus one data output whose driver can be switched off. The bus pins are sampled on a faster system clock. A frame begins with a 1 start bit, then carries a two-bit opcode and a six-bit address, and a sixteen-bit data word for the two commands that need one. Reads stream a stored word back. Writes, single-word erases, erase-all and write-all start a self-timed program cycle when chip-select drops.

The program cycle begins only if chip-select falls after the final frame bit and before any further rising edge of the serial clock. It then runs for a fixed number of system clocks with no serial-clock activity. While the cycle runs, the host raises chip-select and polls the output, which shows busy or ready. The storage is a 64 x 16 register file. Write-type commands are blocked until an enable latch has been set.

Top module: `uw_eeprom`

## Requirements
- R1: After reset every word reads 0xFFFF, the write-enable latch is clear and `do_en_o` is low.
- R2: With chip-select high, 0 bits before the start bit are ignored. After the 1 start bit come two opcode bits (10 read, 01 write, 11 erase, 00 extended), then six address bits MSB first, then sixteen data bits MSB first for write and write-all. An extended opcode picks its command from address bits [5:4]: 11 enable, 00 disable, 10 erase-all, 01 write-all.
- R3: On the rising serial-clock edge that samples the last address bit of a read, the output drives a 0. Each of the next sixteen rising edges then presents the next bit of the addressed word, MSB first.
- R4: A completed write replaces the addressed word with the shifted data word, whatever the word held before.
- R5: A completed erase sets the addressed word to 0xFFFF. A completed erase-all sets every word to 0xFFFF.
- R6: A completed write-all stores the shifted data word in every location.
- R7: A program cycle starts only if chip-select falls after the final bit is sampled and before the next rising serial-clock edge. An extra rising edge in that gap cancels the command.
- R8: If chip-select falls before a frame is complete, the array stays unchanged and the next frame decodes normally.
- R9: Write, erase, erase-all and write-all have no effect and start no program cycle unless the enable command has been received. The disable command blocks them again. Both take effect on the last address bit.
- R10: After a program cycle starts, raising chip-select drives the output 0 while the cycle runs (PROG_CYCLES system clocks, no serial clock needed) and 1 once it ends. Start bits are ignored while busy. The status output ends when the next start bit is accepted.
- R11: `do_en_o` is low whenever the synchronised chip-select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip-select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data into the block |
| do_o | output | 1 | Serial data or status out |
| do_en_o | output | 1 | Output driver enable; low means high-impedance |

## Verification
The assertions assume the host holds data steady around each serial-clock rise. They also assume chip-select never changes in the same system-clock window as a serial-clock edge, so edge order is the one the host intends. The stimulus keeps every serial-clock phase at least four system clocks long and changes data only while the serial clock is low. It moves chip-select only with the serial clock low and several system clocks away from any edge. Early and late chip-select drops are produced on purpose by ending a frame short or by adding one extra clock pulse.

// File: rtl/uw_pkg.sv
package uw_pkg;
    typedef enum logic [1:0] {PK_WRITE, PK_ERASE, PK_ERAL, PK_WRAL} prog_kind_e;
    typedef enum logic [2:0] {F_IDLE, F_START, F_OP, F_ADDR, F_DATA, F_READ, F_ARMED, F_DEAD} frame_st_e;
    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;
    localparam logic [1:0] EXT_DIS  = 2'b00;
    localparam logic [1:0] EXT_WRAL = 2'b01;
    localparam logic [1:0] EXT_ERAL = 2'b10;
    localparam logic [1:0] EXT_EN   = 2'b11;
endpackage

// File: rtl/uw_sync.sv
module uw_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;
    logic [W-1:0]             prev_d, prev_q;

    always_comb begin
        chain_d[0] = raw_i;
        for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
        prev_d = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= '0;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~prev_q;
    assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/uw_array.sv
module uw_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              all_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_comb begin
            mem_d[g] = mem_q[g];
            if (we_i && (all_i || waddr_i == ADDR_W'(g))) mem_d[g] = wdata_i;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '1;
            else        mem_q[g] <= mem_d[g];
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/uw_frame.sv
module uw_frame
    import uw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl_i,
    input  logic              cs_fall_i,
    input  logic              sk_rise_i,
    input  logic              di_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              prog_go_o,
    output prog_kind_e        prog_kind_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [DATA_W-1:0] prog_data_o,
    output logic              reading_o,
    output logic              rd_bit_o,
    output logic              start_ok_o,
    output logic              wr_en_o
);
    localparam int MAXL  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int CNT_W = $clog2(MAXL + 1);

    typedef struct packed {
        frame_st_e         st;
        logic [1:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] sreg;
        logic              dout;
        logic [CNT_W-1:0]  cnt;
        prog_kind_e        kind;
        logic              wen;
    } frame_t;

    frame_t d, q;
    logic [ADDR_W-1:0] addr_nx;
    logic [DATA_W-1:0] data_nx;

    always_comb begin
        d          = q;
        prog_go_o  = 1'b0;
        start_ok_o = 1'b0;
        addr_nx    = {q.addr[ADDR_W-2:0], di_i};
        data_nx    = {q.data[DATA_W-2:0], di_i};
        if (!cs_lvl_i) begin
            prog_go_o = cs_fall_i && (q.st == F_ARMED);
            d.st   = F_IDLE;
            d.cnt  = '0;
            d.dout = 1'b0;
        end else begin
            unique case (q.st)
                F_IDLE: d.st = F_START;
                F_START: if (sk_rise_i && di_i && !busy_i) begin
                    d.st       = F_OP;
                    d.cnt      = '0;
                    start_ok_o = 1'b1;
                end
                F_OP: if (sk_rise_i) begin
                    d.op = {q.op[0], di_i};
                    if (q.cnt == CNT_W'(1)) begin
                        d.st  = F_ADDR;
                        d.cnt = '0;
                    end else d.cnt = q.cnt + 1'b1;
                end
                F_ADDR: if (sk_rise_i) begin
                    d.addr = addr_nx;
                    if (q.cnt == CNT_W'(ADDR_W - 1)) begin
                        d.cnt = '0;
                        d.st  = F_DEAD;
                        unique case (q.op)
                            OP_READ: begin
                                d.st   = F_READ;
                                d.sreg = rdata_i;
                                d.dout = 1'b0;
                            end
                            OP_WRITE: begin
                                d.st   = F_DATA;
                                d.kind = PK_WRITE;
                            end
                            OP_ERASE: begin
                                d.kind = PK_ERASE;
                                if (q.wen) d.st = F_ARMED;
                            end
                            default: begin
                                unique case (addr_nx[ADDR_W-1 -: 2])
                                    EXT_ERAL: begin
                                        d.kind = PK_ERAL;
                                        if (q.wen) d.st = F_ARMED;
                                    end
                                    EXT_WRAL: begin
                                        d.st   = F_DATA;
                                        d.kind = PK_WRAL;
                                    end
                                    EXT_EN:  d.wen = 1'b1;
                                    default: d.wen = 1'b0;
                                endcase
                            end
                        endcase
                    end else d.cnt = q.cnt + 1'b1;
                end
                F_DATA: if (sk_rise_i) begin
                    d.data = data_nx;
                    if (q.cnt == CNT_W'(DATA_W - 1)) begin
                        d.cnt = '0;
                        d.st  = q.wen ? F_ARMED : F_DEAD;
                    end else d.cnt = q.cnt + 1'b1;
                end
                F_ARMED: if (sk_rise_i) d.st = F_DEAD;
                F_READ: if (sk_rise_i && q.cnt != CNT_W'(DATA_W)) begin
                    d.dout = q.sreg[DATA_W-1];
                    d.sreg = {q.sreg[DATA_W-2:0], 1'b0};
                    d.cnt  = q.cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= F_IDLE;
            q.kind <= PK_WRITE;
        end else begin
            q <= d;
        end
    end

    assign rd_addr_o   = addr_nx;
    assign prog_kind_o = q.kind;
    assign prog_addr_o = q.addr;
    assign prog_data_o = q.data;
    assign reading_o   = (q.st == F_READ);
    assign rd_bit_o    = q.dout;
    assign wr_en_o     = q.wen;
endmodule

// File: rtl/uw_eeprom.sv
module uw_eeprom
    import uw_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o,
    output logic do_en_o
);
    localparam int TMR_W = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        logic              busy;
        logic              pend;
        logic [TMR_W-1:0]  tmr;
        prog_kind_e        kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ctl_t;

    ctl_t d, q;

    logic [2:0]        lvl, rise, fall;
    logic              cs_lvl, cs_fall, sk_rise, di_s;
    logic [ADDR_W-1:0] rd_addr, prog_addr;
    logic [DATA_W-1:0] rdata, prog_data, arr_wdata;
    logic              prog_go, reading, rd_bit, start_ok, wr_en;
    logic              arr_we, arr_all, busy;
    prog_kind_e        prog_kind;

    uw_sync #(.STAGES(SYNC_STAGES), .W(3)) sync_i (
        .clk(clk), .rst_n(rst_n), .raw_i({di_i, sk_i, cs_i}),
        .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    assign cs_lvl  = lvl[0];
    assign cs_fall = fall[0];
    assign sk_rise = rise[1];
    assign di_s    = lvl[2];

    uw_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) frame_i (
        .clk(clk), .rst_n(rst_n), .cs_lvl_i(cs_lvl), .cs_fall_i(cs_fall),
        .sk_rise_i(sk_rise), .di_i(di_s), .busy_i(q.busy), .rdata_i(rdata),
        .rd_addr_o(rd_addr), .prog_go_o(prog_go), .prog_kind_o(prog_kind),
        .prog_addr_o(prog_addr), .prog_data_o(prog_data), .reading_o(reading),
        .rd_bit_o(rd_bit), .start_ok_o(start_ok), .wr_en_o(wr_en)
    );

    uw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
        .clk(clk), .rst_n(rst_n), .we_i(arr_we), .all_i(arr_all),
        .waddr_i(q.addr), .wdata_i(arr_wdata), .raddr_i(rd_addr), .rdata_o(rdata)
    );

    always_comb begin
        d = q;
        if (q.busy) begin
            if (q.tmr == '0) d.busy = 1'b0;
            else             d.tmr  = q.tmr - 1'b1;
        end
        if (prog_go) begin
            d.busy = 1'b1;
            d.pend = 1'b1;
            d.tmr  = TMR_W'(PROG_CYCLES - 1);
            d.kind = prog_kind;
            d.addr = prog_addr;
            d.data = prog_data;
        end
        if (start_ok) d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.kind <= PK_WRITE;
        end else begin
            q <= d;
        end
    end

    assign busy      = q.busy;
    assign arr_we    = q.busy && (q.tmr == '0);
    assign arr_all   = (q.kind == PK_ERAL) || (q.kind == PK_WRAL);
    assign arr_wdata = ((q.kind == PK_WRITE) || (q.kind == PK_WRAL)) ? q.data : '1;
    assign do_en_o   = cs_lvl && (reading || q.pend);
    assign do_o      = reading ? rd_bit : ~q.busy;
endmodule

// File: rtl/uw_eeprom_chk.sv
module uw_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_lvl,
    input logic do_en,
    input logic reading,
    input logic prog_go,
    input logic busy,
    input logic start_ok,
    input logic arr_we,
    input logic wr_en
);
    // R11
    hiz_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_lvl |-> !do_en);
    // R3
    read_drives_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reading && cs_lvl) |-> do_en);
    // R10
    go_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |=> busy);
    // R10
    no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start_ok);
    // R9
    go_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> wr_en);
    // R7
    go_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> !cs_lvl);
    // R10
    commit_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && !prog_go) |=> !busy);
endmodule

bind uw_eeprom uw_eeprom_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .do_en(do_en_o),
    .reading(reading), .prog_go(prog_go), .busy(busy), .start_ok(start_ok),
    .arr_we(arr_we), .wr_en(wr_en)
);

// File: tb/uw_eeprom_tb_top.sv
module uw_eeprom_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    wire  dout, den;

    always #2.5 clk = ~clk;

    uw_eeprom dut_i (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
        .do_o(dout), .do_en_o(den)
    );

    int total = 0;
    int bad = 0;
    logic smp, smp_en;
    logic [15:0] model [64];
    logic [15:0] exp_q[$];
    logic [15:0] obs_q[$];
    string       tag_q[$];
    event        obs_ev;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clk_n(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(input logic b);
        di = b;
        clk_n(4);
        sk = 1'b1;
        clk_n(5);
        smp = dout;
        smp_en = den;
        sk = 1'b0;
    endtask

    task automatic head(input logic [1:0] op, input logic [5:0] a, input int pad);
        cs = 1'b1;
        clk_n(4);
        for (int i = 0; i < pad; i++) pulse(1'b0);
        pulse(1'b1);
        pulse(op[1]);
        pulse(op[0]);
        for (int i = 5; i >= 0; i--) pulse(a[i]);
    endtask

    task automatic data16(input logic [15:0] w, input int nbits);
        for (int i = 15; i > 15 - nbits; i--) pulse(w[i]);
    endtask

    task automatic finish_frame(input bit late);
        if (late) pulse(1'b0);
        clk_n(2);
        cs = 1'b0;
        clk_n(6);
    endtask

    task automatic poll_ready(input string tag, output int waited);
        waited = 0;
        cs = 1'b1;
        clk_n(6);
        while (!(den === 1'b1 && dout === 1'b1) && waited < 2000) begin
            clk_n(1);
            waited++;
        end
        chk(tag, {31'd0, den & dout}, 32'd1);
        cs = 1'b0;
        clk_n(6);
    endtask

    task automatic read_word(input logic [5:0] a, input int pad, input string tag);
        logic [15:0] w;
        exp_q.push_back(model[a]);
        tag_q.push_back(tag);
        head(2'b10, a, pad);
        chk({"R3 dummy bit ", tag}, {30'd0, smp_en, smp}, 32'd2);
        w = '0;
        for (int i = 0; i < 16; i++) begin
            pulse(1'b0);
            w = {w[14:0], smp};
        end
        cs = 1'b0;
        clk_n(6);
        obs_q.push_back(w);
        ->obs_ev;
    endtask

    initial begin : monitor
        forever begin
            @(obs_ev);
            while (obs_q.size() > 0 && exp_q.size() > 0)
                chk(tag_q.pop_front(), {16'd0, obs_q.pop_front()}, {16'd0, exp_q.pop_front()});
        end
    end

    task automatic en_cmd(input bit on);
        head(2'b00, on ? 6'b110000 : 6'b000000, 0);
        finish_frame(1'b0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : driver
        int waited;
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        clk_n(5);
        rst_n = 1'b1;
        clk_n(3);
        chk("R1 output disabled after reset", {31'd0, den}, 32'd0);
        read_word(6'd0, 0, "R1 word 0 erased");
        read_word(6'd63, 0, "R1 word 63 erased");

        // R9: write before enable is ignored, no status
        head(2'b01, 6'd5, 0); data16(16'hA5C3, 16); finish_frame(1'b0);
        cs = 1'b1; clk_n(8);
        chk("R9 no status without enable", {31'd0, den}, 32'd0);
        cs = 1'b0; clk_n(6);
        read_word(6'd5, 0, "R9 disabled write ignored");

        en_cmd(1'b1);
        // R10 busy then ready
        head(2'b01, 6'd5, 0); data16(16'hA5C3, 16); finish_frame(1'b0);
        model[5] = 16'hA5C3;
        cs = 1'b1; clk_n(8);
        chk("R10 busy status", {30'd0, den, dout}, 32'd2);
        cs = 1'b0; clk_n(2);
        chk("R11 high-Z with CS low", {31'd0, den}, 32'd0);
        poll_ready("R10 ready status", waited);
        chk("R10 busy lasts program time", {31'd0, waited > 120}, 32'd1);
        read_word(6'd5, 0, "R4 write stored");

        head(2'b01, 6'd5, 0); data16(16'h1234, 16); finish_frame(1'b0);
        model[5] = 16'h1234;
        poll_ready("R10 ready after rewrite", waited);
        read_word(6'd5, 2, "R4 overwrite without erase, R2 leading zeros");

        // R7 late CS drop
        head(2'b01, 6'd6, 0); data16(16'h5555, 16); finish_frame(1'b1);
        cs = 1'b1; clk_n(8);
        chk("R7 no cycle after late deselect", {31'd0, den}, 32'd0);
        cs = 1'b0; clk_n(6);
        read_word(6'd6, 0, "R7 late deselect unchanged");

        // R8 early CS drop
        head(2'b01, 6'd7, 0); data16(16'h0F00, 8); finish_frame(1'b0);
        read_word(6'd7, 0, "R8 short frame unchanged");
        head(2'b01, 6'd7, 0); data16(16'h00FF, 16); finish_frame(1'b0);
        model[7] = 16'h00FF;
        poll_ready("R8 next frame accepted", waited);
        read_word(6'd7, 0, "R8 decoding resumes");

        head(2'b11, 6'd5, 0); finish_frame(1'b0);
        model[5] = 16'hFFFF;
        poll_ready("R5 erase ready", waited);
        read_word(6'd5, 0, "R5 erase word");

        head(2'b00, 6'b010000, 0); data16(16'h0F0F, 16); finish_frame(1'b0);
        for (int i = 0; i < 64; i++) model[i] = 16'h0F0F;
        poll_ready("R6 write-all ready", waited);
        read_word(6'd0, 0, "R6 write-all word 0");
        read_word(6'd6, 0, "R6 write-all word 6");
        read_word(6'd63, 0, "R6 write-all word 63");

        head(2'b00, 6'b100000, 0); finish_frame(1'b0);
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        poll_ready("R5 erase-all ready", waited);
        read_word(6'd0, 0, "R5 erase-all word 0");
        read_word(6'd63, 0, "R5 erase-all word 63");

        // R10 start bits ignored while busy
        head(2'b01, 6'd9, 0); data16(16'hBEEF, 16); finish_frame(1'b0);
        model[9] = 16'hBEEF;
        cs = 1'b1; clk_n(8);
        pulse(1'b1); pulse(1'b1); pulse(1'b1);
        chk("R10 start ignored while busy", {30'd0, smp_en, smp}, 32'd2);
        cs = 1'b0; clk_n(6);
        poll_ready("R10 ready after ignored starts", waited);
        read_word(6'd9, 0, "R4 word after busy pulses");

        en_cmd(1'b0);
        head(2'b11, 6'd9, 0); finish_frame(1'b0);
        cs = 1'b1; clk_n(8);
        chk("R9 no status after disable", {31'd0, den}, 32'd0);
        cs = 1'b0; clk_n(6);
        read_word(6'd9, 0, "R9 erase blocked after disable");

        clk_n(10);
        chk("R2 all reads compared", exp_q.size() + obs_q.size(), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule